// File: doc/BRIEF.md
# Endpoint-Zero OUT Control Register

This block is the device-side control and status register that governs OUT transactions on USB endpoint 0. A CPU reads and writes it one byte at a time. The register holds the data toggle bit, a forced-NAK flag, a forced-STALL flag and an option that re-arms the forced NAK automatically. The transaction engine feeds it four events:

- transaction in progress
- transaction finished normally
- setup stage complete
- toggle advance

From its own state and the FIFO free-space count, the block tells the engine which handshake to return.

Writing 1 to the forced-NAK flag while a transaction is running is held as a pending request. The flag is set once the bus goes idle. Setup completion sets the flag. While the external protect input is high, a CPU write cannot clear it. The toggle bit is driven by write-one strobes, and a clear strobe beats a set strobe.

Top module: `usb_ep0_out_ctrl`

## Requirements
- R1: After reset the read value is 8'h00 and the handshake output is ACK (code 2'b00).
- R2: The toggle state reads at bit 4. Writing a byte with bit 3 = 1 sets the toggle, writing bit 2 = 1 clears it, and writing 0 to both bits leaves it unchanged.
- R3: A write with bits 3 and 2 both at 1 clears the toggle to 0.
- R4: A toggle-advance pulse inverts the toggle. A CPU set or clear strobe in the same cycle overrides the inversion.
- R5: The forced-NAK flag (bit 1, readable) is set at once by a write of 1 when no transaction is active. A write of 0 clears it when the protect input is low.
- R6: A write of 1 to bit 1 while a transaction is active does not change the flag during that transaction. The flag becomes 1 at the first clock edge at which the transaction-active input is low.
- R7: A setup-complete pulse sets the forced-NAK flag. While the protect input is high, a write of 0 to bit 1 leaves the flag at 1.
- R8: Bit 7 is a readable auto-NAK enable. While it is 1, a normal transaction end sets the forced-NAK flag.
- R9: The handshake is registered, one cycle after the state it reflects. It is STALL (2'b10) when the forced-STALL flag (bit 0, readable) is 1. Otherwise it is NAK (2'b01) when the forced-NAK flag is 1 or the FIFO free space is below MAX_PKT. Otherwise it is ACK (2'b00).
- R10: Bits 6, 5, 3 and 2 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Byte write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read value |
| xact_busy | input | 1 | OUT transaction in progress |
| xact_ok | input | 1 | Pulse: transaction ended normally |
| setup_end | input | 1 | Pulse: setup stage complete |
| tog_adv | input | 1 | Pulse: invert toggle after accepted data |
| nak_protect | input | 1 | Blocks CPU clear of forced NAK |
| fifo_room | input | FIFO_AW | FIFO free space in bytes |
| hs_sel | output | 2 | Handshake: 00 ACK, 01 NAK, 10 STALL |

## Verification
Every register bit becomes visible on the read port after the clock edge that samples the write or event, so it is due one cycle after the stimulus. The handshake code is due one cycle after that. The bench drives inputs on falling edges. It reads the register after one rising edge and reads the handshake after a second rising edge. For the deferred request, the flag is sampled on each busy cycle and again just after the first idle edge.

// File: rtl/ep0o_pkg.sv
package ep0o_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  localparam int B_AUTO  = 7;
  localparam int B_TOG   = 4;
  localparam int B_TSET  = 3;
  localparam int B_TCLR  = 2;
  localparam int B_NAK   = 1;
  localparam int B_STALL = 0;
endpackage

// File: rtl/ep0o_toggle.sv
module ep0o_toggle (
  input  logic clk,
  input  logic rst,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic adv,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst)          tog <= 1'b0;
    else if (clr_stb) tog <= 1'b0;
    else if (set_stb) tog <= 1'b1;
    else if (adv)     tog <= ~tog;
  end
endmodule

// File: rtl/ep0o_nak.sv
module ep0o_nak (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wbit,
  input  logic busy,
  input  logic ok_end,
  input  logic setup_end,
  input  logic auto_en,
  input  logic protect,
  output logic nak
);
  logic pend;
  logic set_now;
  logic clr_now;

  always_comb begin
    set_now = setup_end
            | (ok_end & auto_en)
            | (wr & wbit & ~busy)
            | (pend & ~busy);
    clr_now = wr & ~wbit & ~protect;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nak  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (set_now)      nak <= 1'b1;
      else if (clr_now) nak <= 1'b0;

      if (wr & wbit & busy)  pend <= 1'b1;
      else if (~busy)        pend <= 1'b0;
      else if (clr_now)      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ep0o_hs_sel.sv
module ep0o_hs_sel #(
  parameter int FIFO_AW = 7,
  parameter int MAX_PKT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic               nak,
  input  logic [FIFO_AW-1:0] room,
  output ep0o_pkg::hs_e      hs
);
  import ep0o_pkg::*;
  localparam logic [FIFO_AW-1:0] NEED = FIFO_AW'(MAX_PKT);

  always_ff @(posedge clk) begin
    if (rst)                      hs <= HS_ACK;
    else if (stall)               hs <= HS_STALL;
    else if (nak || room < NEED)  hs <= HS_NAK;
    else                          hs <= HS_ACK;
  end
endmodule

// File: rtl/usb_ep0_out_ctrl.sv
module usb_ep0_out_ctrl #(
  parameter int FIFO_AW = 7,
  parameter int MAX_PKT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_wr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic               xact_busy,
  input  logic               xact_ok,
  input  logic               setup_end,
  input  logic               tog_adv,
  input  logic               nak_protect,
  input  logic [FIFO_AW-1:0] fifo_room,
  output logic [1:0]         hs_sel
);
  import ep0o_pkg::*;

  logic auto_en, stall_q, tog, nak;
  hs_e  hs;

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_en <= 1'b0;
      stall_q <= 1'b0;
    end else if (cpu_wr) begin
      auto_en <= cpu_wdata[B_AUTO];
      stall_q <= cpu_wdata[B_STALL];
    end
  end

  ep0o_toggle u_tog (
    .clk(clk), .rst(rst),
    .set_stb(cpu_wr & cpu_wdata[B_TSET]),
    .clr_stb(cpu_wr & cpu_wdata[B_TCLR]),
    .adv(tog_adv), .tog(tog)
  );

  ep0o_nak u_nak (
    .clk(clk), .rst(rst), .wr(cpu_wr), .wbit(cpu_wdata[B_NAK]),
    .busy(xact_busy), .ok_end(xact_ok), .setup_end(setup_end),
    .auto_en(auto_en), .protect(nak_protect), .nak(nak)
  );

  ep0o_hs_sel #(.FIFO_AW(FIFO_AW), .MAX_PKT(MAX_PKT)) u_hs (
    .clk(clk), .rst(rst), .stall(stall_q), .nak(nak),
    .room(fifo_room), .hs(hs)
  );

  always_comb begin
    cpu_rdata         = 8'h00;
    cpu_rdata[B_AUTO] = auto_en;
    cpu_rdata[B_TOG]  = tog;
    cpu_rdata[B_NAK]  = nak;
    cpu_rdata[B_STALL]= stall_q;
  end

  assign hs_sel = hs;
endmodule

// File: rtl/ep0o_chk.sv
module ep0o_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic       xact_busy,
  input logic       xact_ok,
  input logic       setup_end,
  input logic       nak_protect,
  input logic [1:0] hs_sel
);
  // R3
  tog_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && cpu_wdata[2] |=> !cpu_rdata[4]);
  // R2
  tog_set_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && cpu_wdata[3] && !cpu_wdata[2] |=> cpu_rdata[4]);
  // R7
  setup_sets_nak_chk: assert property (@(posedge clk) disable iff (rst)
    setup_end |=> cpu_rdata[1]);
  // R7
  protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    nak_protect && cpu_rdata[1] |=> cpu_rdata[1]);
  // R6
  deferred_nak_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && cpu_wdata[1] && xact_busy && !cpu_rdata[1] && !setup_end
      && !(xact_ok && cpu_rdata[7]) |=> !cpu_rdata[1]);
  // R9
  stall_first_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[0] |=> hs_sel == 2'b10);
  // R10
  always @(posedge clk)
    if (!rst) reserved_zero_chk: assert (cpu_rdata[6:5] == 2'b00 && cpu_rdata[3:2] == 2'b00);
endmodule

bind usb_ep0_out_ctrl ep0o_chk u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata), .xact_busy(xact_busy), .xact_ok(xact_ok),
  .setup_end(setup_end), .nak_protect(nak_protect), .hs_sel(hs_sel)
);

// File: tb/usb_ep0_out_ctrl_tb.sv
module usb_ep0_out_ctrl_tb_top;
  localparam int AW = 7;
  localparam int MP = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic xact_busy = 1'b0, xact_ok = 1'b0, setup_end = 1'b0, tog_adv = 1'b0;
  logic nak_protect = 1'b0;
  logic [AW-1:0] fifo_room = 7'd100;
  logic [1:0] hs_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_ep0_out_ctrl #(.FIFO_AW(AW), .MAX_PKT(MP)) dut_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .xact_busy(xact_busy), .xact_ok(xact_ok),
    .setup_end(setup_end), .tog_adv(tog_adv), .nak_protect(nak_protect),
    .fifo_room(fifo_room), .hs_sel(hs_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0; cpu_wdata = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 rdata", cpu_rdata, 8'h00);
    chk("R1 hs", {6'b0, hs_sel}, 8'h00);
  endtask

  task automatic t_toggle;
    wr(8'h08); chk("R2 set", {7'b0, cpu_rdata[4]}, 8'h01);
    wr(8'h00); chk("R2 zero write", {7'b0, cpu_rdata[4]}, 8'h01);
    wr(8'h04); chk("R2 clear", {7'b0, cpu_rdata[4]}, 8'h00);
    wr(8'h08); wr(8'h0C); chk("R3 both", {7'b0, cpu_rdata[4]}, 8'h00);
  endtask

  task automatic t_adv;
    @(negedge clk); tog_adv = 1'b1;
    @(negedge clk); tog_adv = 1'b0;
    chk("R4 invert", {7'b0, cpu_rdata[4]}, 8'h01);
    @(negedge clk); tog_adv = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h08;
    @(negedge clk); tog_adv = 1'b0; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    chk("R4 set overrides", {7'b0, cpu_rdata[4]}, 8'h01);
    @(negedge clk); tog_adv = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h04;
    @(negedge clk); tog_adv = 1'b0; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    chk("R4 clear overrides", {7'b0, cpu_rdata[4]}, 8'h00);
  endtask

  task automatic t_nak;
    wr(8'h02); chk("R5 set idle", {7'b0, cpu_rdata[1]}, 8'h01);
    @(negedge clk); chk("R9 nak hs", {6'b0, hs_sel}, 8'h01);
    wr(8'h00); chk("R5 clear", {7'b0, cpu_rdata[1]}, 8'h00);
    @(negedge clk); chk("R9 ack hs", {6'b0, hs_sel}, 8'h00);
  endtask

  task automatic t_defer;
    @(negedge clk); xact_busy = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h02;
    @(negedge clk); cpu_wr = 1'b0; cpu_wdata = 8'h00;
    chk("R6 held", {7'b0, cpu_rdata[1]}, 8'h00);
    @(negedge clk); chk("R6 still held", {7'b0, cpu_rdata[1]}, 8'h00);
    xact_busy = 1'b0;
    @(negedge clk); chk("R6 applied", {7'b0, cpu_rdata[1]}, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_setup;
    @(negedge clk); setup_end = 1'b1; nak_protect = 1'b1;
    @(negedge clk); setup_end = 1'b0;
    chk("R7 setup sets", {7'b0, cpu_rdata[1]}, 8'h01);
    wr(8'h00); chk("R7 protected", {7'b0, cpu_rdata[1]}, 8'h01);
    nak_protect = 1'b0;
    wr(8'h00); chk("R7 unprotected clear", {7'b0, cpu_rdata[1]}, 8'h00);
  endtask

  task automatic t_auto;
    wr(8'h80); chk("R8 auto bit", cpu_rdata, 8'h80);
    @(negedge clk); xact_ok = 1'b1;
    @(negedge clk); xact_ok = 1'b0;
    chk("R8 auto nak", {7'b0, cpu_rdata[1]}, 8'h01);
    wr(8'h00); chk("R8 cleared", cpu_rdata, 8'h00);
    @(negedge clk); xact_ok = 1'b1;
    @(negedge clk); xact_ok = 1'b0;
    chk("R8 no auto", {7'b0, cpu_rdata[1]}, 8'h00);
  endtask

  task automatic t_hs;
    fifo_room = 7'd63;
    @(negedge clk); @(negedge clk); chk("R9 low room nak", {6'b0, hs_sel}, 8'h01);
    fifo_room = 7'd64;
    @(negedge clk); chk("R9 room ok ack", {6'b0, hs_sel}, 8'h00);
    fifo_room = 7'd10;
    wr(8'h03); @(negedge clk); chk("R9 stall first", {6'b0, hs_sel}, 8'h02);
    fifo_room = 7'd100;
    wr(8'h00); @(negedge clk); chk("R9 back ack", {6'b0, hs_sel}, 8'h00);
  endtask

  task automatic t_resv;
    wr(8'hFF);
    chk("R10 reserved", cpu_rdata & 8'h6C, 8'h00);
    wr(8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset; t_toggle; t_adv; t_nak; t_defer; t_setup; t_auto; t_hs; t_resv;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule